// File: doc/BRIEF.md
# Lane Mask Unit

This unit turns a compact mask operand into a per-lane predicate for a 32-lane SIMD wave. It then uses that predicate in three data operations and in the branch test. A wave has a single flow of control, so any behaviour that differs from lane to lane has to come from this predicate. The operand names two mask registers from a small file in which each register holds one bit per lane. Either register can be inverted, and the two are then combined with a bitwise AND.

The unit supports three data operations:

- **Masked move** passes a source to the destination and enables the write only on the predicated lanes.
- **Select** chooses between two sources on each lane.
- **Find-first** extracts one scalar from the lowest enabled lane.

Every issued operation also produces the all-lanes and any-lane branch conditions. A data source can be a full vector, or a scalar that is copied to every lane. All results are registered.

Top module: `lane_mask_unit`

## Requirements
- R1: `mask_op` holds two 6-bit fields. Bits [4:0] are the index of register A and bit 5 inverts A. Bits [10:6] are the index of register B and bit 11 inverts B. Bit i of the predicate is (A[i] XOR invA) AND (B[i] XOR invB).
- R2: Masked move (op 1) drives `res_vec` with the true source on every lane and drives `res_we` equal to the predicate.
- R3: Select (op 2) drives each lane of `res_vec` with the true source where the predicate bit is 1 and with the false source where it is 0. All bits of `res_we` are 1.
- R4: When `bcast_t` or `bcast_f` is 1, the matching source is `scl_t` or `scl_f` copied to every lane, in place of the vector input.
- R5: Find-first (op 3) with a nonzero predicate loads `scl_out` with the true-source value of the lowest-numbered predicated lane and raises `scl_vld`.
- R6: Find-first with an all-zero predicate keeps `scl_vld` low and leaves `scl_out` unchanged. `scl_out` also keeps its value through every other operation.
- R7: `br_all` is 1 after an issued operation only when all 32 predicate bits are 1.
- R8: `br_any` is 1 after an issued operation when at least one predicate bit is 1.
- R9: Every result appears one cycle after the issuing clock edge. A cycle without `op_valid` yields `res_we`=0, `scl_vld`=0, `br_all`=0 and `br_any`=0. Ops other than 1 and 2 write no lanes.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issue strobe |
| op | input | 3 | 0 none, 1 move, 2 select, 3 find-first, 4 branch test |
| mask_op | input | 12 | Two-register mask operand |
| mask_regs | input | 1024 | 32 mask registers, register r at bits [r*32 +: 32] |
| vec_t | input | 1024 | True source vector, lane i at bits [i*32 +: 32] |
| vec_f | input | 1024 | False source vector |
| scl_t | input | 32 | True source scalar |
| scl_f | input | 32 | False source scalar |
| bcast_t | input | 1 | Use the scalar as the true source |
| bcast_f | input | 1 | Use the scalar as the false source |
| res_vec | output | 1024 | Result vector |
| res_we | output | 32 | Per-lane write enable |
| scl_out | output | 32 | Scalar result |
| scl_vld | output | 1 | Scalar result written this cycle |
| br_all | output | 1 | All predicate bits set |
| br_any | output | 1 | Some predicate bit set |

## Verification
Every output, including the held scalar, is due exactly one rising edge after the edge that sampled the issue. An idle cycle is also due one edge later, as cleared strobes and flags. The driver applies each operation on a falling edge and queues the expected outputs for that operation. The monitor removes one queued item per rising edge and compares it 1 ns after that edge, so each comparison lands in the cycle its result is due. A fixed-latency regression would pair the wrong items and be flagged.

// File: rtl/lmask_pkg.sv
package lmask_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_MOVE  = 3'd1,
    OP_SEL   = 3'd2,
    OP_FIRST = 3'd3,
    OP_BR    = 3'd4
  } op_e;

  // Apply an optional inversion to a 32-lane mask word.
  function automatic logic [31:0] cond_inv(input logic [31:0] m, input logic inv);
    return inv ? ~m : m;
  endfunction

endpackage

// File: rtl/lmask_decode.sv
module lmask_decode #(
  parameter int LANES = 32,
  parameter int MREGS = 32,
  localparam int IDX_W = $clog2(MREGS),
  localparam int FLD_W = IDX_W + 1,
  localparam int MOP_W = 2 * FLD_W
) (
  input  logic [MREGS*LANES-1:0] regs,
  input  logic [MOP_W-1:0]       mop,
  output logic [LANES-1:0]       pred
);

  logic [IDX_W-1:0] idx_a, idx_b;
  logic             inv_a, inv_b;
  logic [LANES-1:0] ra, rb;

  assign idx_a = mop[IDX_W-1:0];
  assign inv_a = mop[IDX_W];
  assign idx_b = mop[FLD_W+IDX_W-1:FLD_W];
  assign inv_b = mop[MOP_W-1];

  assign ra = regs[idx_a*LANES +: LANES];
  assign rb = regs[idx_b*LANES +: LANES];

  // Each operand is optionally inverted, then the two are ANDed per lane.
  assign pred = (inv_a ? ~ra : ra) & (inv_b ? ~rb : rb);

endmodule

// File: rtl/lmask_source.sv
module lmask_source #(
  parameter int LANES = 32,
  parameter int W     = 32
) (
  input  logic [LANES*W-1:0] vec_in,
  input  logic [W-1:0]       scl_in,
  input  logic               bcast,
  output logic [LANES*W-1:0] vec_out
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign vec_out[g*W +: W] = bcast ? scl_in : vec_in[g*W +: W];
  end

endmodule

// File: rtl/lmask_first.sv
module lmask_first #(
  parameter int LANES = 32,
  parameter int W     = 32,
  localparam int IW   = $clog2(LANES)
) (
  input  logic [LANES-1:0]   pred,
  input  logic [LANES*W-1:0] vec,
  output logic               found,
  output logic [W-1:0]       value
);

  logic [IW-1:0] idx;

  // Scan from the top down so the lowest set lane is the one left in idx.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pred[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  assign value = vec[idx*W +: W];

endmodule

// File: rtl/lane_mask_unit.sv
module lane_mask_unit #(
  parameter int LANES = 32,
  parameter int MREGS = 32,
  parameter int W     = 32,
  localparam int MOP_W = 2 * ($clog2(MREGS) + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [2:0]             op,
  input  logic [MOP_W-1:0]       mask_op,
  input  logic [MREGS*LANES-1:0] mask_regs,
  input  logic [LANES*W-1:0]     vec_t,
  input  logic [LANES*W-1:0]     vec_f,
  input  logic [W-1:0]           scl_t,
  input  logic [W-1:0]           scl_f,
  input  logic                   bcast_t,
  input  logic                   bcast_f,
  output logic [LANES*W-1:0]     res_vec,
  output logic [LANES-1:0]       res_we,
  output logic [W-1:0]           scl_out,
  output logic                   scl_vld,
  output logic                   br_all,
  output logic                   br_any
);
  import lmask_pkg::*;

  logic [LANES-1:0]   pred_w;
  logic [LANES*W-1:0] src_t, src_f, sel_vec;
  logic               first_hit;
  logic [W-1:0]       first_val;
  op_e                opc;

  assign opc = op_e'(op);

  lmask_decode #(.LANES(LANES), .MREGS(MREGS)) u_dec (
    .regs(mask_regs), .mop(mask_op), .pred(pred_w)
  );

  lmask_source #(.LANES(LANES), .W(W)) u_src_t (
    .vec_in(vec_t), .scl_in(scl_t), .bcast(bcast_t), .vec_out(src_t)
  );

  lmask_source #(.LANES(LANES), .W(W)) u_src_f (
    .vec_in(vec_f), .scl_in(scl_f), .bcast(bcast_f), .vec_out(src_f)
  );

  lmask_first #(.LANES(LANES), .W(W)) u_first (
    .pred(pred_w), .vec(src_t), .found(first_hit), .value(first_val)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_sel
    assign sel_vec[g*W +: W] = pred_w[g] ? src_t[g*W +: W] : src_f[g*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vec <= '0;
      res_we  <= '0;
      scl_out <= '0;
      scl_vld <= 1'b0;
      br_all  <= 1'b0;
      br_any  <= 1'b0;
    end else begin
      // Strobes and flags clear by default; scl_out holds its value.
      res_vec <= '0;
      res_we  <= '0;
      scl_vld <= 1'b0;
      br_all  <= 1'b0;
      br_any  <= 1'b0;
      if (op_valid) begin
        br_all <= &pred_w;
        br_any <= |pred_w;
        case (opc)
          OP_MOVE: begin
            res_vec <= src_t;
            res_we  <= pred_w;
          end
          OP_SEL: begin
            res_vec <= sel_vec;
            res_we  <= '1;
          end
          OP_FIRST: begin
            if (first_hit) begin
              scl_out <= first_val;
              scl_vld <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/lmask_chk.sv
module lmask_chk #(
  parameter int LANES = 32,
  parameter int W     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [2:0]       op,
  input logic [LANES-1:0] pred,
  input logic [LANES-1:0] res_we,
  input logic [W-1:0]     scl_out,
  input logic             scl_vld,
  input logic             br_all,
  input logic             br_any
);

  a_r2_move_we: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 3'd1) |=> (res_we == $past(pred)));

  a_r3_sel_all_we: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 3'd2) |=> (&res_we));

  a_r5_vld_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
    scl_vld |-> br_any);

  a_r6_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 3'd3 && pred == '0) |=> (!scl_vld && $stable(scl_out)));

  a_r8_all_implies_any: assert property (@(posedge clk) disable iff (!rst_n)
    br_all |-> br_any);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (res_we == '0 && !scl_vld && !br_all && !br_any));

  a_r9_no_stray_vld: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op != 3'd3) |=> (!scl_vld && $stable(scl_out)));

endmodule

bind lane_mask_unit lmask_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .pred(pred_w),
  .res_we(res_we), .scl_out(scl_out), .scl_vld(scl_vld),
  .br_all(br_all), .br_any(br_any)
);

// File: tb/sim_lane_mask_unit.sv
`timescale 1ns/1ps
module sim_lane_mask_unit;
  localparam int L = 32;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           op_valid = 1'b0;
  logic [2:0]     op = '0;
  logic [11:0]    mask_op = '0;
  logic [L*L-1:0] mask_regs;
  logic [L*W-1:0] vec_t, vec_f;
  logic [W-1:0]   scl_t = '0, scl_f = '0;
  logic           bcast_t = 1'b0, bcast_f = 1'b0;
  logic [L*W-1:0] res_vec;
  logic [L-1:0]   res_we;
  logic [W-1:0]   scl_out;
  logic           scl_vld, br_all, br_any;

  always #2.5 clk = ~clk;

  lane_mask_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .mask_op(mask_op),
    .mask_regs(mask_regs), .vec_t(vec_t), .vec_f(vec_f), .scl_t(scl_t),
    .scl_f(scl_f), .bcast_t(bcast_t), .bcast_f(bcast_f), .res_vec(res_vec),
    .res_we(res_we), .scl_out(scl_out), .scl_vld(scl_vld), .br_all(br_all),
    .br_any(br_any)
  );

  int total = 0, bad = 0;
  bit done = 0;

  logic [W-1:0] mr[L];
  logic [W-1:0] tv[L], fv[L];
  logic [W-1:0] held_scl = '0;

  typedef struct {
    logic [L*W-1:0] vec;
    logic [L-1:0]   we;
    logic [W-1:0]   scl;
    logic           vld, all, any;
  } exp_t;
  exp_t  q[$];
  string rq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mop(input int ia, input bit inva, input int ib, input bit invb);
    logic [4:0] a5 = 5'(ia);
    logic [4:0] b5 = 5'(ib);
    return {invb, b5, inva, a5};
  endfunction

  task automatic issue(input logic [2:0] o, input logic [11:0] m,
                       input bit bt, input logic [W-1:0] st,
                       input bit bf, input logic [W-1:0] sf, input string req);
    exp_t e;
    logic [L-1:0] p;
    logic [W-1:0] te, fe;
    bit hit;
    @(negedge clk);
    op_valid = 1'b1; op = o; mask_op = m;
    bcast_t = bt; scl_t = st; bcast_f = bf; scl_f = sf;
    for (int i = 0; i < L; i++)
      p[i] = (mr[m[4:0]][i] ^ m[5]) & (mr[m[10:6]][i] ^ m[11]);
    e.vec = '0; e.we = '0; e.vld = 1'b0;
    hit = 0;
    for (int i = 0; i < L; i++) begin
      te = bt ? st : tv[i];
      fe = bf ? sf : fv[i];
      if (o == 3'd1) begin e.vec[i*W +: W] = te; e.we[i] = p[i]; end
      if (o == 3'd2) begin e.vec[i*W +: W] = p[i] ? te : fe; e.we[i] = 1'b1; end
      if (o == 3'd3 && p[i] && !hit) begin hit = 1; held_scl = te; e.vld = 1'b1; end
    end
    e.scl = held_scl;
    e.all = (p == {L{1'b1}});
    e.any = (p != '0);
    q.push_back(e); rq.push_back(req);
  endtask

  task automatic idle(input string req);
    exp_t e;
    @(negedge clk);
    op_valid = 1'b0; op = 3'd0;
    e.vec = '0; e.we = '0; e.scl = held_scl; e.vld = 0; e.all = 0; e.any = 0;
    q.push_back(e); rq.push_back(req);
  endtask

  // Monitor: one expected item per rising edge, compared 1 ns later.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        string r;
        e = q.pop_front();
        r = rq.pop_front();
        check(res_vec == e.vec, r, "res_vec", res_vec, e.vec);
        check(res_we == e.we, r, "res_we", L*W'(res_we), L*W'(e.we));
        check(scl_vld == e.vld, r, "scl_vld", L*W'(scl_vld), L*W'(e.vld));
        check(scl_out == e.scl, r, "scl_out", L*W'(scl_out), L*W'(e.scl));
        check(br_all == e.all, r, "br_all", L*W'(br_all), L*W'(e.all));
        check(br_any == e.any, r, "br_any", L*W'(br_any), L*W'(e.any));
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always_comb
    for (int i = 0; i < L; i++) begin
      mask_regs[i*L +: L] = mr[i];
      vec_t[i*W +: W] = tv[i];
      vec_f[i*W +: W] = fv[i];
    end

  initial begin
    for (int i = 0; i < L; i++) begin
      mr[i] = (32'h9E37_79B9 * (i + 3)) ^ (32'h0F0F_00FF << (i % 7));
      tv[i] = 32'hA000_0000 + 32'(i * 17);
      fv[i] = 32'h5000_0000 + 32'(i * 3);
    end
    mr[0] = 32'h0;
    mr[1] = 32'hFFFF_FFFF;
    mr[5] = 32'h0000_0020;
    mr[6] = 32'h8000_0000;
    mr[7] = 32'h0000_0001;
    mr[8] = 32'hF0F0_1234;
    mr[9] = 32'h3C3C_FF00;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check(res_we == '0 && res_vec == '0, "R10", "reset vec/we", L*W'(res_we), '0);
    check({scl_vld, br_all, br_any} == 3'b0 && scl_out == '0, "R10", "reset scalar/flags",
          L*W'({scl_out, scl_vld, br_all, br_any}), '0);
    @(negedge clk); rst_n = 1'b1;

    issue(3'd1, mop(8, 0, 9, 0), 0, '0, 0, '0, "R1_R2 move plain");
    issue(3'd1, mop(8, 1, 9, 0), 0, '0, 0, '0, "R1 move invA");
    issue(3'd1, mop(8, 0, 9, 1), 0, '0, 0, '0, "R1 move invB");
    issue(3'd1, mop(12, 1, 8, 1), 1, 32'hCAFE_0001, 0, '0, "R4_R2 move bcast");
    issue(3'd2, mop(8, 0, 9, 0), 0, '0, 0, '0, "R3 select vec");
    issue(3'd2, mop(20, 0, 1, 0), 0, '0, 1, 32'hBEEF_0002, "R3_R4 select bcast false");
    issue(3'd2, mop(0, 0, 1, 0), 1, 32'h1111_0003, 0, '0, "R3_R4 select none true");
    issue(3'd3, mop(5, 0, 1, 0), 0, '0, 0, '0, "R5 first lane5");
    issue(3'd3, mop(6, 0, 1, 0), 0, '0, 0, '0, "R5 first lane31");
    issue(3'd3, mop(8, 0, 9, 0), 0, '0, 0, '0, "R5 first mixed");
    issue(3'd3, mop(0, 1, 7, 0), 0, '0, 0, '0, "R5 first lane0");
    issue(3'd3, mop(5, 0, 7, 0), 0, '0, 0, '0, "R6 first empty holds");
    issue(3'd3, mop(0, 0, 0, 0), 1, 32'h7777_7777, 0, '0, "R6 empty bcast holds");
    idle("R6_R9 idle hold");
    issue(3'd3, mop(6, 0, 1, 0), 1, 32'hD00D_0004, 0, '0, "R5_R4 first bcast");
    issue(3'd4, mop(0, 1, 0, 1), 0, '0, 0, '0, "R7 all set");
    issue(3'd4, mop(7, 0, 1, 0), 0, '0, 0, '0, "R8 one lane");
    issue(3'd4, mop(6, 1, 1, 0), 0, '0, 0, '0, "R7_R8 31 lanes");
    issue(3'd4, mop(0, 0, 1, 0), 0, '0, 0, '0, "R8 none");
    issue(3'd0, mop(1, 0, 1, 0), 0, '0, 0, '0, "R9 op none writes nothing");
    idle("R9 idle");
    issue(3'd7, mop(8, 0, 9, 0), 0, '0, 0, '0, "R9 unused op");
    idle("R9 idle2");
    idle("R9 idle3");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule